// File: doc/BRIEF.md
# DRAM Memory-Cycle Classifier

This block sits on the device side of an asynchronous page-mode DRAM interface and watches the four active-low strobes: row strobe, column strobe, write enable and output enable. Each strobe passes through a synchroniser into a fast sampling clock. The block then works out what kind of memory cycle the controller is running, using only the order in which the strobe edges arrive. It reports one cycle-type code each time the row strobe returns high.

The block also models the device's internal refresh row counter. Cycles that refresh with the column strobe held low take their row from this counter and then increment it. All other cycles take their row from the address pins at the falling edge of the row strobe. A data-output-enable signal follows the same edge ordering and shows when the device would drive its data pins. Analog timing limits are not checked. Edges that land in the same sample are resolved by a fixed priority.

Top module: `dram_cycle_classifier`

## Requirements
- R1: While reset is asserted and after it is released with all strobes high, `cyc_valid`=0, `cyc_kind`=0, `row_out`=0 and `dout_en`=0.
- R2: If the column strobe is low in the sample where the row strobe falls, the cycle is a counter refresh. `row_out` takes the counter value, the counter then increments modulo 2^ROW_W, the address pins are ignored, and `dout_en` stays 0. The code is 6.
- R3: If the column strobe stays high for the whole row-strobe low period, the cycle is a row-only refresh with code 5. `row_out` holds the address sampled when the row strobe fell, and later address changes have no effect on it.
- R4: A cycle whose column strobe fell with write enable high, and in which no write occurred, is a read with code 1. During such a read, `dout_en` is 1 while column strobe and output enable are low and write enable is high.
- R5: If write enable is low in the sample where the column strobe falls, that column access is an early write. The cycle code is 2 and `dout_en` stays 0 for that column access.
- R6: If write enable falls while the column strobe was already low, the cycle is a late write with code 3. If a read access occurred earlier in the same cycle, it is a read-modify-write with code 4. The priority is hidden 7 > counter refresh 6 > 4 > 3 > 2 > read 1 > row-only 5.
- R7: A hidden refresh occurs when the column strobe is held low after a read while the row strobe rises and falls again. The code is 7, the row comes from the counter and the counter increments. `dout_en` stays 1 throughout, as long as output enable stays low and write enable stays high.
- R8: `dout_en` is 0 whenever the column strobe is high or write enable is low.
- R9: `cyc_valid` is a one-sample pulse, issued once per row-strobe low period at its rising edge. `cyc_kind` is 0 whenever `cyc_valid` is 0.
- R10: In a single sample, a row-strobe fall together with a column-strobe fall counts as column-before-row, and a write-enable fall together with a column-strobe fall counts as an early write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, asynchronous, active low |
| cas_n | input | 1 | Column strobe, asynchronous, active low |
| we_n | input | 1 | Write enable, asynchronous, active low |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| addr | input | ROW_W | Multiplexed address pins |
| cyc_valid | output | 1 | One-sample pulse when a cycle completes |
| cyc_kind | output | 3 | Cycle-type code, 0 when idle |
| row_out | output | ROW_W | Row used by the current or most recent cycle |
| dout_en | output | 1 | Device would drive its data pins |

## Verification
The bench sweeps every combination of write-enable timing (before, together with, after the column strobe, or never) against every output-enable timing. A design that confused same-sample write enable with a late write, or that let a read follow a write, would report code 3 or 4 where 2 is due, or would raise `dout_en` during an early write. A run of counter refreshes that passes the counter wrap, some started with both strobes falling in the same sample, catches a counter that skips, reuses a row, or reads the address pins. A hidden refresh between two reads checks that `dout_en` holds across the row-strobe bounce. Row-only refreshes that change the address after the row strobe falls expose a row register that keeps sampling.

// File: rtl/dram_cycle_classifier.sv
module dram_cycle_classifier #(
  parameter int ROW_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [ROW_W-1:0] addr,
  output logic             cyc_valid,
  output logic [2:0]       cyc_kind,
  output logic [ROW_W-1:0] row_out,
  output logic             dout_en
);

  localparam logic [2:0] K_IDLE = 3'd0;
  localparam logic [2:0] K_RD   = 3'd1;
  localparam logic [2:0] K_EWR  = 3'd2;
  localparam logic [2:0] K_LWR  = 3'd3;
  localparam logic [2:0] K_RMW  = 3'd4;
  localparam logic [2:0] K_ROR  = 3'd5;
  localparam logic [2:0] K_CBR  = 3'd6;
  localparam logic [2:0] K_HID  = 3'd7;

  logic [SYNC_STAGES-1:0] sy_r, sy_c, sy_w, sy_o;
  logic s_r, s_c, s_w, s_o, p_r, p_c, p_w;
  logic cbr_f, hid_f, cs_f, rd_f, ew_f, lw_f, rmw_f, ewc_f, hold_f;
  logic cbr_n, hid_n, cs_n, rd_n, ew_n, lw_n, rmw_n, ewc_n, hold_n;
  logic [ROW_W-1:0] cnt;
  logic [2:0] kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy_r <= '1; sy_c <= '1; sy_w <= '1; sy_o <= '1;
      p_r <= 1'b1; p_c <= 1'b1; p_w <= 1'b1;
    end else begin
      sy_r <= {sy_r[SYNC_STAGES-2:0], ras_n};
      sy_c <= {sy_c[SYNC_STAGES-2:0], cas_n};
      sy_w <= {sy_w[SYNC_STAGES-2:0], we_n};
      sy_o <= {sy_o[SYNC_STAGES-2:0], oe_n};
      p_r <= s_r; p_c <= s_c; p_w <= s_w;
    end
  end

  assign s_r = sy_r[SYNC_STAGES-1];
  assign s_c = sy_c[SYNC_STAGES-1];
  assign s_w = sy_w[SYNC_STAGES-1];
  assign s_o = sy_o[SYNC_STAGES-1];

  wire ras_fall = p_r & ~s_r;
  wire ras_rise = ~p_r & s_r;
  wire cas_fall = p_c & ~s_c;
  wire we_fall  = p_w & ~s_w;
  wire acc      = ~s_r & ~cbr_n;
  wire ew_now   = cas_fall & acc & ~s_w;
  wire lw_now   = acc & ~s_c & ~p_c & we_fall & ~ewc_f;
  wire rd_now   = acc & ~s_c & ~s_o & s_w & ~ewc_n;

  assign cbr_n  = ras_fall ? ~s_c : (ras_rise ? 1'b0 : cbr_f);
  assign hid_n  = ras_fall ? (~s_c & hold_f) : (ras_rise ? 1'b0 : hid_f);
  assign ewc_n  = s_c ? 1'b0 : (ewc_f | ew_now);
  assign ew_n   = ~ras_rise & (ew_f | ew_now);
  assign lw_n   = ~ras_rise & (lw_f | lw_now);
  assign rmw_n  = ~ras_rise & (rmw_f | (lw_now & rd_f));
  assign rd_n   = ~ras_rise & (rd_f | rd_now);
  assign cs_n   = ~ras_rise & (cs_f | (acc & ~s_c));
  assign hold_n = ~s_c & (hold_f | rd_now);

  always_comb begin
    if (hid_f)      kind = K_HID;
    else if (cbr_f) kind = K_CBR;
    else if (rmw_f) kind = K_RMW;
    else if (lw_f)  kind = K_LWR;
    else if (ew_f)  kind = K_EWR;
    else if (cs_f)  kind = K_RD;
    else            kind = K_ROR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cbr_f <= 1'b0; hid_f <= 1'b0; cs_f <= 1'b0; rd_f <= 1'b0;
      ew_f <= 1'b0; lw_f <= 1'b0; rmw_f <= 1'b0; ewc_f <= 1'b0; hold_f <= 1'b0;
      cnt <= '0; row_out <= '0;
      cyc_valid <= 1'b0; cyc_kind <= K_IDLE; dout_en <= 1'b0;
    end else begin
      cbr_f <= cbr_n; hid_f <= hid_n; cs_f <= cs_n; rd_f <= rd_n;
      ew_f <= ew_n; lw_f <= lw_n; rmw_f <= rmw_n; ewc_f <= ewc_n; hold_f <= hold_n;
      if (ras_fall) begin
        if (!s_c) begin
          row_out <= cnt;
          cnt     <= cnt + ROW_W'(1);
        end else begin
          row_out <= addr;
        end
      end
      cyc_valid <= ras_rise;
      cyc_kind  <= ras_rise ? kind : K_IDLE;
      dout_en   <= ~s_c & ~s_o & s_w & ~ewc_n & ((~s_r & ~cbr_n) | hid_n | hold_n);
    end
  end

  p_cbr_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ras_fall && !s_c |=> row_out == $past(cnt) && cnt == $past(cnt) + ROW_W'(1));
  p_cbr_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cbr_f && !hid_f |-> !dout_en);
  p_ror_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ras_fall && s_c |=> row_out == $past(addr) && $stable(cnt));
  p_early_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ewc_f |-> !dout_en);
  p_cas_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    s_c |=> !dout_en);
  p_we_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !s_w |=> !dout_en);
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |=> !cyc_valid);
  p_idle_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |-> cyc_kind == K_IDLE);

endmodule

// File: tb/sim_dram_cycle_classifier.sv
module sim_dram_cycle_classifier;
  localparam int RW = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [RW-1:0] addr = '0;
  logic cyc_valid, dout_en;
  logic [2:0] cyc_kind;
  logic [RW-1:0] row_out;

  int n_chk = 0, n_fail = 0, n_rep = 0, cycles = 0;
  int last_kind = 0, exp_cnt = 0, r0 = 0;
  bit done = 0;

  dram_cycle_classifier #(.ROW_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .cyc_valid(cyc_valid), .cyc_kind(cyc_kind), .row_out(row_out), .dout_en(dout_en));

  always #5 clk = ~clk;

  always @(negedge clk) if (cyc_valid) begin n_rep++; last_kind = cyc_kind; end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic expect_report(input string tag, input int k);
    check({tag, " report count"}, n_rep, r0 + 1);
    check({tag, " code"}, last_kind, k);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", cyc_valid, 0);
    check("R1 dout in reset", dout_en, 0);
    rst_n = 1'b1;
    settle();
    check("R1 valid", cyc_valid, 0);
    check("R1 kind", cyc_kind, 0);
    check("R1 row", row_out, 0);
    check("R1 dout", dout_en, 0);

    // R3 row-only refresh over every address
    for (int a = 0; a < 16; a++) begin
      addr = a[RW-1:0]; ras_n = 0; settle();
      check("R3 row latched", row_out, a);
      addr = ~a[RW-1:0]; settle();
      check("R3 later address ignored", row_out, a);
      check("R8 dout with CAS high", dout_en, 0);
      r0 = n_rep; ras_n = 1; settle();
      expect_report("R3", 5);
    end

    // R4 R5 R6 R10 sweep of WE timing (wp) against OE timing (op)
    for (int wp = 0; wp < 4; wp++) begin
      for (int op = 0; op < 3; op++) begin
        int ek;
        addr = RW'(wp * 3 + op); ras_n = 0;
        if (wp == 0) we_n = 0;
        if (op == 0) oe_n = 0;
        settle();
        check("R8 dout before CAS", dout_en, 0);
        cas_n = 0;
        if (wp == 1) we_n = 0;
        settle();
        check("R4/R5 dout after CAS fall", dout_en, int'(wp >= 2 && op == 0));
        if (op == 1) oe_n = 0;
        settle();
        check("R4/R5 dout after OE", dout_en, int'(wp >= 2 && op <= 1));
        if (wp == 2) we_n = 0;
        settle();
        check("R8 dout after late WE", dout_en, int'(wp == 3 && op <= 1));
        r0 = n_rep; ras_n = 1; settle();
        ek = (wp <= 1) ? 2 : (wp == 2) ? ((op <= 1) ? 4 : 3) : 1;
        expect_report("R5/R6/R4 sweep", ek);
        cas_n = 1; we_n = 1; oe_n = 1; settle();
        check("R8 dout all high", dout_en, 0);
      end
    end

    // R6 page mode: read access, then early write in same row cycle
    ras_n = 0; settle();
    oe_n = 0; cas_n = 0; settle();
    check("R4 page read dout", dout_en, 1);
    cas_n = 1; settle();
    check("R8 dout CAS precharge", dout_en, 0);
    we_n = 0; cas_n = 0; settle();
    check("R5 page early write dout", dout_en, 0);
    r0 = n_rep; ras_n = 1; settle();
    expect_report("R6 priority", 2);
    cas_n = 1; we_n = 1; oe_n = 1; settle();

    // R7 hidden refresh after a read
    addr = 4'h9; ras_n = 0; settle();
    cas_n = 0; oe_n = 0; settle();
    check("R4 read dout", dout_en, 1);
    r0 = n_rep; ras_n = 1; settle();
    expect_report("R4 before hidden", 1);
    check("R7 dout held across RAS high", dout_en, 1);
    ras_n = 0; addr = 4'h3; settle();
    check("R7 dout held in hidden", dout_en, 1);
    check("R7 row from counter", row_out, exp_cnt);
    r0 = n_rep; ras_n = 1; settle();
    expect_report("R7", 7);
    exp_cnt = (exp_cnt + 1) % 16;
    cas_n = 1; oe_n = 1; settle();
    check("R8 dout after hidden", dout_en, 0);

    // R2 R10 counter refresh past the wrap, output enable held low
    oe_n = 0;
    for (int i = 0; i < 20; i++) begin
      addr = RW'(15 - (i % 16));
      if (i % 5 == 0) begin
        cas_n = 0; ras_n = 0; settle();
      end else begin
        cas_n = 0; settle();
        check("R2 dout before RAS", dout_en, 0);
        ras_n = 0; settle();
      end
      check("R2/R10 row from counter", row_out, exp_cnt);
      check("R2 dout during refresh", dout_en, 0);
      r0 = n_rep; ras_n = 1; settle();
      expect_report("R2/R10", 6);
      exp_cnt = (exp_cnt + 1) % 16;
      cas_n = 1; settle();
    end
    oe_n = 1; settle();
    check("R9 idle kind", cyc_kind, 0);
    check("R9 idle valid", cyc_valid, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule